// File: doc/BRIEF.md
# Configurable True Dual-Port RAM

This block is a synchronous memory with two symmetric read/write ports, A and B, clocked by a single clock. Each port has the following inputs:

- an address
- write data
- a write strobe
- a read strobe
- one write-enable bit per byte lane
- a stall input that freezes the port's address register
- a synchronous clear and an asynchronous clear for its output

Build parameters set several behaviours:

- the lane width
- the word width and depth
- whether each port has an extra output register
- whether an idle read cycle drives the output to zero
- how a read behaves when a write to the same location happens in the same cycle

The read-during-write behaviour is set separately for a write from the same port and for a write from the other port.

The memory samples the effective address, write data and strobes on a rising edge. The read word is captured in a read register on that same edge. With the output register enabled, the word reaches the port one edge later. When both ports write one location on the same edge, port A's lanes land on top of port B's.

Top module: `twin_port_ram`

## Requirements
- R1: After `rst_n` is released, every location reads as zero and both `*_q` outputs are zero.
- R2: A read with `*_ren` high presents the word at the effective address after one rising edge when `OUT_REG`=0, and after two edges when `OUT_REG`=1.
- R3: Bit i of `*_lane_en` enables data bits [i*LANE_W +: LANE_W] (bit 0 is the least significant lane). Lanes whose bit is clear keep their previous contents. `LANE_W` must be 5, 8, 9 or 10 and must divide `DATA_W`.
- R4: When a port reads the location it writes on the same edge, `SAME_RDW`=RDW_NEW returns the lane-merged new word and RDW_OLD returns the previous contents.
- R5: When a port reads the location the other port writes on the same edge, `MIX_RDW`=RDW_NEW returns the lane-merged new word and RDW_OLD returns the previous contents.
- R6: When both ports write one location on the same edge, port A's enabled lanes win. Lanes enabled only by B take B's data.
- R7: While `*_stall` is high, the port uses the address it held on the previous edge for both reads and writes, and the held address does not change.
- R8: With `FORCE_ZERO`=1, an edge with `*_ren` low loads zero into the port's read register.
- R9: With `FORCE_ZERO`=0, an edge with `*_ren` low leaves the port's read register unchanged.
- R10: With `SCLR_EN`=1, an edge with `*_sclr` high clears both of the port's output registers, so `*_q` is zero afterwards.
- R11: With `ACLR_EN`=1, `*_aclr` high clears the port's output registers at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low asynchronous reset for memory, address and output registers |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_wen | input | 1 | Port A write strobe |
| a_ren | input | 1 | Port A read strobe |
| a_lane_en | input | LANES | Port A per-lane write enables |
| a_stall | input | 1 | Port A address hold |
| a_sclr | input | 1 | Port A synchronous output clear |
| a_aclr | input | 1 | Port A asynchronous output clear |
| a_q | output | DATA_W | Port A read data |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_wen | input | 1 | Port B write strobe |
| b_ren | input | 1 | Port B read strobe |
| b_lane_en | input | LANES | Port B per-lane write enables |
| b_stall | input | 1 | Port B address hold |
| b_sclr | input | 1 | Port B synchronous output clear |
| b_aclr | input | 1 | Port B asynchronous output clear |
| b_q | output | DATA_W | Port B read data |

## Verification
The bench builds two instances with 20-bit words and 16 locations, so every address can be swept. They share all inputs:

- The first instance uses 10-bit lanes, old-data policies on both axes, the output register enabled and force-to-zero disabled.
- The second instance uses 5-bit lanes, new-data policies on both axes, no output register and force-to-zero enabled.

With one stimulus, both read-during-write policies, both latencies, idle-read zeroing and idle-read holding are compared against a reference model in the bench. All sixteen enable patterns of the four-lane instance are covered. A dense pseudo-random phase confined to four addresses makes same-port, cross-port and dual-write collisions frequent.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    typedef enum logic {
        RDW_OLD = 1'b0,
        RDW_NEW = 1'b1
    } rdw_policy_e;

    localparam int PORT_A = 0;
    localparam int PORT_B = 1;
    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/tpr_lane_merge.sv
module tpr_lane_merge #(
    parameter int DATA_W = 20,
    parameter int LANE_W = 10,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] base_word,
    input  logic [DATA_W-1:0] new_word,
    input  logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] merged
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[i*LANE_W +: LANE_W] = lane_en[i] ? new_word[i*LANE_W +: LANE_W]
                                                       : base_word[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/tpr_addr_reg.sv
module tpr_addr_reg #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] held_addr
);

    assign eff_addr = stall ? held_addr : addr_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_addr <= '0;
        end else begin
            held_addr <= eff_addr;
        end
    end

endmodule

// File: rtl/tpr_read_pipe.sv
module tpr_read_pipe #(
    parameter int DATA_W     = 20,
    parameter bit OUT_REG    = 1'b1,
    parameter bit FORCE_ZERO = 1'b0,
    parameter bit SCLR_EN    = 1'b1,
    parameter bit ACLR_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rden,
    input  logic              sclr,
    input  logic              aclr,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] raw_q,
    output logic [DATA_W-1:0] q
);

    logic clr_async;
    logic clr_sync;
    logic [DATA_W-1:0] raw_next;

    assign clr_async = !rst_n || (ACLR_EN && aclr);
    assign clr_sync  = SCLR_EN && sclr;

    always_comb begin
        raw_next = raw_q;
        if (clr_sync) begin
            raw_next = '0;
        end else if (rden) begin
            raw_next = rd_word;
        end else if (FORCE_ZERO) begin
            raw_next = '0;
        end
    end

    always_ff @(posedge clk or posedge clr_async) begin
        if (clr_async) begin
            raw_q <= '0;
        end else begin
            raw_q <= raw_next;
        end
    end

    if (OUT_REG) begin : g_out_reg
        logic [DATA_W-1:0] out_q;
        always_ff @(posedge clk or posedge clr_async) begin
            if (clr_async) begin
                out_q <= '0;
            end else if (clr_sync) begin
                out_q <= '0;
            end else begin
                out_q <= raw_q;
            end
        end
        assign q = out_q;
    end else begin : g_no_out_reg
        assign q = raw_q;
    end

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
    import tpr_pkg::*;
#(
    parameter int          DATA_W     = 20,
    parameter int          LANE_W     = 10,
    parameter int          DEPTH      = 16,
    parameter bit          OUT_REG    = 1'b1,
    parameter bit          FORCE_ZERO = 1'b0,
    parameter bit          SCLR_EN    = 1'b1,
    parameter bit          ACLR_EN    = 1'b1,
    parameter rdw_policy_e SAME_RDW   = RDW_OLD,
    parameter rdw_policy_e MIX_RDW    = RDW_OLD,
    localparam int         LANES      = DATA_W / LANE_W,
    localparam int         ADDR_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_wen,
    input  logic              a_ren,
    input  logic [LANES-1:0]  a_lane_en,
    input  logic              a_stall,
    input  logic              a_sclr,
    input  logic              a_aclr,
    output logic [DATA_W-1:0] a_q,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_wen,
    input  logic              b_ren,
    input  logic [LANES-1:0]  b_lane_en,
    input  logic              b_stall,
    input  logic              b_sclr,
    input  logic              b_aclr,
    output logic [DATA_W-1:0] b_q
);

    if ((DATA_W % LANE_W) != 0 ||
        !(LANE_W == 5 || LANE_W == 8 || LANE_W == 9 || LANE_W == 10)) begin : g_bad_lane
        $error("twin_port_ram: lane width must be 5, 8, 9 or 10 and divide the word width");
    end

    logic [ADDR_W-1:0] port_addr [NUM_PORTS];
    logic [DATA_W-1:0] port_wd   [NUM_PORTS];
    logic [LANES-1:0]  port_be   [NUM_PORTS];
    logic              port_wen  [NUM_PORTS];
    logic              port_ren  [NUM_PORTS];
    logic              port_stl  [NUM_PORTS];
    logic              port_sclr [NUM_PORTS];
    logic              port_aclr [NUM_PORTS];
    logic [ADDR_W-1:0] eff_addr  [NUM_PORTS];
    logic [ADDR_W-1:0] held_addr [NUM_PORTS];
    logic [DATA_W-1:0] rd_word   [NUM_PORTS];
    logic [DATA_W-1:0] raw_q     [NUM_PORTS];
    logic [DATA_W-1:0] port_q    [NUM_PORTS];

    assign port_addr[PORT_A] = a_addr;    assign port_addr[PORT_B] = b_addr;
    assign port_wd[PORT_A]   = a_wdata;   assign port_wd[PORT_B]   = b_wdata;
    assign port_be[PORT_A]   = a_lane_en; assign port_be[PORT_B]   = b_lane_en;
    assign port_wen[PORT_A]  = a_wen;     assign port_wen[PORT_B]  = b_wen;
    assign port_ren[PORT_A]  = a_ren;     assign port_ren[PORT_B]  = b_ren;
    assign port_stl[PORT_A]  = a_stall;   assign port_stl[PORT_B]  = b_stall;
    assign port_sclr[PORT_A] = a_sclr;    assign port_sclr[PORT_B] = b_sclr;
    assign port_aclr[PORT_A] = a_aclr;    assign port_aclr[PORT_B] = b_aclr;
    assign a_q = port_q[PORT_A];
    assign b_q = port_q[PORT_B];

    logic [DATA_W-1:0] mem [DEPTH];

    // Stored words: B's lanes first, A's lanes on top when both hit one location.
    logic              wr_collide;
    logic [DATA_W-1:0] word_b;
    logic [DATA_W-1:0] base_a;
    logic [DATA_W-1:0] word_a;

    assign wr_collide = port_wen[PORT_A] && port_wen[PORT_B] &&
                        (eff_addr[PORT_A] == eff_addr[PORT_B]);

    tpr_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_wr_merge_b (
        .base_word (mem[eff_addr[PORT_B]]),
        .new_word  (port_wd[PORT_B]),
        .lane_en   (port_be[PORT_B]),
        .merged    (word_b)
    );

    assign base_a = wr_collide ? word_b : mem[eff_addr[PORT_A]];

    tpr_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_wr_merge_a (
        .base_word (base_a),
        .new_word  (port_wd[PORT_A]),
        .lane_en   (port_be[PORT_A]),
        .merged    (word_a)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (port_wen[PORT_B]) begin
                mem[eff_addr[PORT_B]] <= word_b;
            end
            if (port_wen[PORT_A]) begin
                mem[eff_addr[PORT_A]] <= word_a;
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam bit B_NEW = (p == PORT_B) ? (SAME_RDW == RDW_NEW) : (MIX_RDW == RDW_NEW);
        localparam bit A_NEW = (p == PORT_A) ? (SAME_RDW == RDW_NEW) : (MIX_RDW == RDW_NEW);

        logic [DATA_W-1:0] old_word;
        logic [DATA_W-1:0] with_b;
        logic [DATA_W-1:0] stage_b;
        logic [DATA_W-1:0] with_a;
        logic              hit_b;
        logic              hit_a;

        tpr_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
            .clk       (clk),
            .rst_n     (rst_n),
            .stall     (port_stl[p]),
            .addr_in   (port_addr[p]),
            .eff_addr  (eff_addr[p]),
            .held_addr (held_addr[p])
        );

        assign old_word = mem[eff_addr[p]];
        assign hit_b = B_NEW && port_wen[PORT_B] && (eff_addr[PORT_B] == eff_addr[p]);
        assign hit_a = A_NEW && port_wen[PORT_A] && (eff_addr[PORT_A] == eff_addr[p]);

        tpr_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rd_merge_b (
            .base_word (old_word),
            .new_word  (port_wd[PORT_B]),
            .lane_en   (port_be[PORT_B]),
            .merged    (with_b)
        );

        assign stage_b = hit_b ? with_b : old_word;

        tpr_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rd_merge_a (
            .base_word (stage_b),
            .new_word  (port_wd[PORT_A]),
            .lane_en   (port_be[PORT_A]),
            .merged    (with_a)
        );

        assign rd_word[p] = hit_a ? with_a : stage_b;

        tpr_read_pipe #(
            .DATA_W     (DATA_W),
            .OUT_REG    (OUT_REG),
            .FORCE_ZERO (FORCE_ZERO),
            .SCLR_EN    (SCLR_EN),
            .ACLR_EN    (ACLR_EN)
        ) u_pipe (
            .clk     (clk),
            .rst_n   (rst_n),
            .rden    (port_ren[p]),
            .sclr    (port_sclr[p]),
            .aclr    (port_aclr[p]),
            .rd_word (rd_word[p]),
            .raw_q   (raw_q[p]),
            .q       (port_q[p])
        );
    end

endmodule

// File: rtl/tpr_checker.sv
module tpr_checker #(
    parameter int DATA_W     = 20,
    parameter int ADDR_W     = 4,
    parameter bit FORCE_ZERO = 1'b0,
    parameter bit SCLR_EN    = 1'b1,
    parameter bit ACLR_EN    = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_ren,
    input logic              b_ren,
    input logic              a_stall,
    input logic              b_stall,
    input logic              a_sclr,
    input logic              b_sclr,
    input logic              a_aclr,
    input logic              b_aclr,
    input logic [DATA_W-1:0] a_q,
    input logic [DATA_W-1:0] b_q,
    input logic [DATA_W-1:0] a_raw,
    input logic [DATA_W-1:0] b_raw,
    input logic [ADDR_W-1:0] a_held,
    input logic [ADDR_W-1:0] b_held
);

    // R7
    a_stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_stall |=> $stable(a_held));
    // R7
    b_stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_stall |=> $stable(b_held));

    // R8
    a_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (FORCE_ZERO && !a_ren) |=> (a_raw == '0));
    // R8
    b_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (FORCE_ZERO && !b_ren) |=> (b_raw == '0));

    // R9
    a_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!FORCE_ZERO && !a_ren && !a_sclr && !a_aclr) ##1 !a_aclr |-> $stable(a_raw));
    // R9
    b_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!FORCE_ZERO && !b_ren && !b_sclr && !b_aclr) ##1 !b_aclr |-> $stable(b_raw));

    // R10
    a_sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SCLR_EN && a_sclr) |=> (a_q == '0));
    // R10
    b_sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SCLR_EN && b_sclr) |=> (b_q == '0));

    // R11
    a_async_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ACLR_EN && a_aclr) |-> (a_q == '0));
    // R11
    b_async_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ACLR_EN && b_aclr) |-> (b_q == '0));

endmodule

bind twin_port_ram tpr_checker #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .FORCE_ZERO (FORCE_ZERO),
    .SCLR_EN    (SCLR_EN),
    .ACLR_EN    (ACLR_EN)
) u_tpr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_ren   (a_ren),
    .b_ren   (b_ren),
    .a_stall (a_stall),
    .b_stall (b_stall),
    .a_sclr  (a_sclr),
    .b_sclr  (b_sclr),
    .a_aclr  (a_aclr),
    .b_aclr  (b_aclr),
    .a_q     (a_q),
    .b_q     (b_q),
    .a_raw   (raw_q[0]),
    .b_raw   (raw_q[1]),
    .a_held  (held_addr[0]),
    .b_held  (held_addr[1])
);

// File: tb/twin_port_ram_bench.sv
module twin_port_ram_bench;
    import tpr_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [3:0]  a_addr, b_addr;
    logic [19:0] a_wdata, b_wdata;
    logic        a_wen, b_wen, a_ren, b_ren, a_stall, b_stall;
    logic        a_sclr, b_sclr, a_aclr, b_aclr;
    logic [3:0]  a_be, b_be;
    logic [19:0] q0a, q0b, q1a, q1b;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // Config 0: 10-bit lanes, old/old, output register, hold on idle.
    twin_port_ram #(
        .DATA_W(20), .LANE_W(10), .DEPTH(16), .OUT_REG(1'b1), .FORCE_ZERO(1'b0),
        .SCLR_EN(1'b1), .ACLR_EN(1'b1), .SAME_RDW(RDW_OLD), .MIX_RDW(RDW_OLD)
    ) u_twin_port_ram (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_wen(a_wen), .a_ren(a_ren),
        .a_lane_en(a_be[1:0]), .a_stall(a_stall), .a_sclr(a_sclr), .a_aclr(a_aclr), .a_q(q0a),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_wen(b_wen), .b_ren(b_ren),
        .b_lane_en(b_be[1:0]), .b_stall(b_stall), .b_sclr(b_sclr), .b_aclr(b_aclr), .b_q(q0b)
    );

    // Config 1: 5-bit lanes, new/new, no output register, zero on idle.
    twin_port_ram #(
        .DATA_W(20), .LANE_W(5), .DEPTH(16), .OUT_REG(1'b0), .FORCE_ZERO(1'b1),
        .SCLR_EN(1'b1), .ACLR_EN(1'b1), .SAME_RDW(RDW_NEW), .MIX_RDW(RDW_NEW)
    ) u_twin_port_ram_alt (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_wen(a_wen), .a_ren(a_ren),
        .a_lane_en(a_be), .a_stall(a_stall), .a_sclr(a_sclr), .a_aclr(a_aclr), .a_q(q1a),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_wen(b_wen), .b_ren(b_ren),
        .b_lane_en(b_be), .b_stall(b_stall), .b_sclr(b_sclr), .b_aclr(b_aclr), .b_q(q1b)
    );

    // Reference model
    int          cfg_lw   [2] = '{10, 5};
    bit          cfg_oreg [2] = '{1'b1, 1'b0};
    bit          cfg_fz   [2] = '{1'b0, 1'b1};
    bit          cfg_new  [2] = '{1'b0, 1'b1};
    logic [19:0] mm    [2][16];
    logic [19:0] raw_m [2][2];
    logic [19:0] out_m [2][2];
    logic [3:0]  areg  [2];
    logic [31:0] rs = 32'h1d2c_3b4a;

    function automatic logic [19:0] mrg(logic [19:0] base, logic [19:0] nw, logic [3:0] be, int lw);
        logic [19:0] r = base;
        for (int b = 0; b < 20; b++) begin
            if (be[b / lw]) r[b] = nw[b];
        end
        return r;
    endfunction

    function automatic logic [31:0] rnd();
        rs ^= rs << 13;
        rs ^= rs >> 17;
        rs ^= rs << 5;
        return rs;
    endfunction

    task automatic model_clear_all();
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 2; p++) begin
                raw_m[c][p] = '0;
                out_m[c][p] = '0;
            end
            for (int i = 0; i < 16; i++) mm[c][i] = '0;
        end
        areg[0] = '0;
        areg[1] = '0;
    endtask

    task automatic cmp(int c, int p);
        logic [19:0] got, exp;
        got = (c == 0) ? ((p == 0) ? q0a : q0b) : ((p == 0) ? q1a : q1b);
        exp = cfg_oreg[c] ? out_m[c][p] : raw_m[c][p];
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s cfg%0d port%0d got=%h exp=%h at %0t", tag, c, p, got, exp, $time);
        end
    endtask

    task automatic cmp_all();
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 2; p++) cmp(c, p);
        end
    endtask

    task automatic tick();
        logic [3:0]  eff [2];
        logic [19:0] wd  [2];
        logic [3:0]  be  [2];
        logic        we  [2];
        logic        re  [2];
        logic        sc  [2];
        logic        ac  [2];
        logic [19:0] rdv [2];
        logic [19:0] nraw;
        @(posedge clk);
        eff[0] = a_stall ? areg[0] : a_addr;
        eff[1] = b_stall ? areg[1] : b_addr;
        wd[0] = a_wdata; wd[1] = b_wdata;
        be[0] = a_be;    be[1] = b_be;
        we[0] = a_wen;   we[1] = b_wen;
        re[0] = a_ren;   re[1] = b_ren;
        sc[0] = a_sclr;  sc[1] = b_sclr;
        ac[0] = a_aclr;  ac[1] = b_aclr;
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 2; p++) begin
                rdv[p] = mm[c][eff[p]];
                if (cfg_new[c] && we[1] && eff[1] == eff[p]) rdv[p] = mrg(rdv[p], wd[1], be[1], cfg_lw[c]);
                if (cfg_new[c] && we[0] && eff[0] == eff[p]) rdv[p] = mrg(rdv[p], wd[0], be[0], cfg_lw[c]);
            end
            for (int p = 0; p < 2; p++) begin
                if (ac[p] || sc[p]) begin
                    raw_m[c][p] = '0;
                    out_m[c][p] = '0;
                end else begin
                    nraw = re[p] ? rdv[p] : (cfg_fz[c] ? 20'h0 : raw_m[c][p]);
                    out_m[c][p] = raw_m[c][p];
                    raw_m[c][p] = nraw;
                end
            end
            if (we[1]) mm[c][eff[1]] = mrg(mm[c][eff[1]], wd[1], be[1], cfg_lw[c]);
            if (we[0]) mm[c][eff[0]] = mrg(mm[c][eff[0]], wd[0], be[0], cfg_lw[c]);
        end
        areg[0] = eff[0];
        areg[1] = eff[1];
        @(negedge clk);
        cmp_all();
    endtask

    task automatic idle();
        a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
        a_wen = 0; b_wen = 0; a_ren = 0; b_ren = 0; a_stall = 0; b_stall = 0;
        a_sclr = 0; b_sclr = 0; a_aclr = 0; b_aclr = 0; a_be = 4'hf; b_be = 4'hf;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired in phase %s", tag);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        model_clear_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: outputs and every location are zero after reset
        tag = "R1";
        cmp_all();
        for (int i = 0; i < 16; i++) begin
            a_addr = 4'(i); b_addr = 4'(15 - i); a_ren = 1; b_ren = 1;
            tick();
        end
        tick();

        // R2: full-lane writes on A, reads on B, then readback on both ports
        tag = "R2";
        for (int i = 0; i < 16; i++) begin
            a_addr = 4'(i); a_wen = 1; a_wdata = 20'(i * 32'h1357 + 32'h0a5);
            b_addr = 4'(i - 1); b_ren = 1; a_ren = 0;
            tick();
        end
        a_wen = 0;
        for (int i = 0; i < 16; i++) begin
            a_addr = 4'(15 - i); b_addr = 4'(i); a_ren = 1; b_ren = 1;
            tick();
        end
        tick();

        // R3: every lane-enable pattern written on B to one location, read on A
        tag = "R3";
        for (int be = 0; be < 16; be++) begin
            b_addr = 4'd5; b_wen = 1; b_be = 4'(be); b_wdata = 20'(32'hfffff - be * 32'h1111);
            a_addr = 4'd5; a_ren = 1; b_ren = 0;
            tick();
        end
        b_wen = 0; b_be = 4'hf;
        tick(); tick();

        // R4: same-port read during write
        tag = "R4";
        for (int i = 0; i < 8; i++) begin
            a_addr = 4'(i); a_wen = 1; a_ren = 1; a_be = 4'(i + 3); a_wdata = 20'(32'h5a5a5 ^ (i << 7));
            b_ren = 0; b_wen = 0;
            tick();
        end
        a_wen = 0; a_ren = 0;
        for (int i = 0; i < 8; i++) begin
            b_addr = 4'(8 + i); b_wen = 1; b_ren = 1; b_be = 4'(i ^ 4'ha); b_wdata = 20'(32'h3c3c3 + i);
            tick();
        end
        b_wen = 0; b_ren = 0; a_be = 4'hf; b_be = 4'hf;
        tick(); tick();

        // R5: cross-port read during write
        tag = "R5";
        for (int i = 0; i < 8; i++) begin
            a_addr = 4'(i * 2); a_wen = 1; a_wdata = 20'(32'h12345 + i * 32'h111); a_be = 4'(i + 1);
            b_addr = 4'(i * 2); b_ren = 1; b_wen = 0; a_ren = 0;
            tick();
        end
        a_wen = 0; b_ren = 0;
        for (int i = 0; i < 8; i++) begin
            b_addr = 4'(i * 2 + 1); b_wen = 1; b_wdata = 20'(32'hedcba - i * 32'h101); b_be = 4'(15 - i);
            a_addr = 4'(i * 2 + 1); a_ren = 1;
            tick();
        end
        b_wen = 0; a_ren = 0; a_be = 4'hf; b_be = 4'hf;
        tick(); tick();

        // R6: both ports write one location; A's lanes must win
        tag = "R6";
        for (int i = 0; i < 8; i++) begin
            a_addr = 4'd7; b_addr = 4'd7; a_wen = 1; b_wen = 1;
            a_wdata = 20'(32'haaaaa ^ i); b_wdata = 20'(32'h55555 + i);
            a_be = 4'(i); b_be = 4'hf; a_ren = 0; b_ren = 0;
            tick();
            a_wen = 0; b_wen = 0; a_ren = 1; b_ren = 1;
            tick(); tick();
        end
        a_ren = 0; b_ren = 0; a_be = 4'hf; b_be = 4'hf;

        // R7: stall keeps the held address for reads and writes
        tag = "R7";
        a_addr = 4'd9; b_addr = 4'd10; a_ren = 1; b_ren = 1;
        tick();
        a_stall = 1; b_stall = 1;
        for (int i = 0; i < 6; i++) begin
            a_addr = 4'(i); b_addr = 4'(15 - i);
            a_wen = (i == 2); a_wdata = 20'h0beef;
            b_wen = (i == 4); b_wdata = 20'h0cafe;
            tick();
        end
        a_stall = 0; b_stall = 0; a_wen = 0; b_wen = 0;
        a_addr = 4'd9; b_addr = 4'd10;
        tick(); tick();

        // R8 R9: idle read cycles (zero on cfg1, hold on cfg0)
        tag = "R8 R9";
        a_ren = 0; b_ren = 0;
        for (int i = 0; i < 4; i++) tick();
        a_ren = 1; b_ren = 1; a_addr = 4'd3; b_addr = 4'd4;
        tick();
        a_ren = 0; b_ren = 0;
        for (int i = 0; i < 3; i++) tick();

        // R10: synchronous clear
        tag = "R10";
        a_ren = 1; b_ren = 1; a_addr = 4'd1; b_addr = 4'd2;
        tick(); tick();
        a_sclr = 1;
        tick();
        a_sclr = 0; b_sclr = 1; a_ren = 0;
        tick();
        b_sclr = 0; b_ren = 0;
        tick(); tick();

        // R11: asynchronous clear takes effect before the next edge
        tag = "R11";
        a_ren = 1; b_ren = 1; a_addr = 4'd6; b_addr = 4'd11;
        tick(); tick();
        a_aclr = 1;
        for (int c = 0; c < 2; c++) begin
            raw_m[c][0] = '0;
            out_m[c][0] = '0;
        end
        #2;
        cmp(0, 0); cmp(1, 0);
        tick();
        a_aclr = 0;
        tick();
        b_aclr = 1;
        for (int c = 0; c < 2; c++) begin
            raw_m[c][1] = '0;
            out_m[c][1] = '0;
        end
        #2;
        cmp(0, 1); cmp(1, 1);
        tick();
        b_aclr = 0;
        tick(); tick();

        // R2 R4 R5 R6 R7: dense pseudo-random traffic on four locations
        tag = "R2 R4 R5 R6 R7 random";
        for (int i = 0; i < 800; i++) begin
            logic [31:0] r0, r1;
            r0 = rnd(); r1 = rnd();
            a_addr = 4'(r0[1:0]); b_addr = 4'(r0[3:2]);
            a_wen = r0[4]; b_wen = r0[5]; a_ren = r0[6] | r0[7]; b_ren = r0[8] | r0[9];
            a_stall = (r0[12:10] == 0); b_stall = (r0[15:13] == 0);
            a_sclr = (r0[20:16] == 0); b_sclr = (r0[25:21] == 0);
            a_be = r0[29:26]; b_be = {r0[31:30], r0[27:26]} ^ 4'h5;
            a_wdata = r1[19:0]; b_wdata = r1[31:12];
            tick();
        end
        idle();
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule